// File: doc/BRIEF.md
# Synthesizer Three-Wire Serial Loader

This block loads an external frequency synthesizer over a three-line serial link made of a data line, a clock line and a latch-enable line. When the device goes from OFF to ON and the synthesizer function is enabled, the block captures two frequency words. It shifts each word out MSB first. A latch-enable pulse follows each word, and the synthesizer copies the shifted bits into its divider registers on that pulse.

The serial stream runs at a fixed rate in base clocks. A pause is added at two points: in the low phase of the 13th bit of each word, and between the first latch pulse and the second word. The length of the pause comes from the receive data-rate selection. An oscillator-enable output and a busy output stay high for the whole transfer.

Top module: `synth_loader`

## Requirements
- R1: After reset, `syn_data`, `syn_clk`, `syn_le`, `osc_en` and `busy` are all low.
- R2: A transfer starts when a clock edge samples `dev_on`=1 and `fn_en`=1, and the previous edge sampled `dev_on`=0. The first bit appears in the cycle after that edge.
- R3: A rise of `dev_on` while `fn_en`=0 starts nothing. Holding `dev_on` high starts nothing either.
- R4: `word_a` is sent first and `word_b` second. Each word is sent from bit WORD_W-1 down to bit 0.
- R5: Each bit holds the clock low for HALF_CLKS cycles and then high for HALF_CLKS cycles. The data line changes only when the clock falls or while the clock is low.
- R6: The low phase of bit number PAUSE_BIT (counting from 1, default 13) of each word lasts HALF_CLKS plus the pause.
- R7: The pause is selected by `rate_sel`: 2'b00 gives PAUSE_SLOW (119), 2'b01 gives PAUSE_MID (33), and 2'b10 or 2'b11 gives PAUSE_FAST (1).
- R8: After the last bit of each word, `syn_le` is high for 2*HALF_CLKS cycles, with the clock and data low.
- R9: Between the first latch pulse and the first bit of the second word, all three lines stay low for HALF_CLKS plus the pause.
- R10: `busy` and `osc_en` are high from the first bit through the last cycle of the second latch pulse. Triggers seen during that time are ignored. Words and rate are captured at the start, so later changes to them have no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_a | input | WORD_W | First frequency word |
| word_b | input | WORD_W | Second frequency word |
| rate_sel | input | 2 | Receive data-rate select, which sets the pause |
| fn_en | input | 1 | Synthesizer loading enabled |
| dev_on | input | 1 | Device ON status |
| syn_data | output | 1 | Serial data to the synthesizer |
| syn_clk | output | 1 | Serial clock; idles low |
| syn_le | output | 1 | Latch-enable pulse |
| osc_en | output | 1 | Synthesizer oscillator enable |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the block with HALF_CLKS=2 and leaves the default pauses of 119, 33 and 1 cycles, so every transfer is only a few hundred cycles long. This lets all four rate codes run to completion, including the long 119-cycle stretch and the single-cycle pause. It also leaves room to re-trigger mid-transfer and to change the words mid-transfer. Every cycle is compared against a queue-based model. The total busy length of each transfer is also checked against a closed-form count of bits, pauses and latch pulses.

// File: rtl/synth_loader.sv
module synth_loader #(
  parameter int WORD_W     = 24,
  parameter int HALF_CLKS  = 4,
  parameter int PAUSE_BIT  = 13,
  parameter int PAUSE_SLOW = 119,
  parameter int PAUSE_MID  = 33,
  parameter int PAUSE_FAST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  input  logic [1:0]        rate_sel,
  input  logic              fn_en,
  input  logic              dev_on,
  output logic              syn_data,
  output logic              syn_clk,
  output logic              syn_le,
  output logic              osc_en,
  output logic              busy
);
  localparam int PMAX0 = (PAUSE_SLOW > PAUSE_MID) ? PAUSE_SLOW : PAUSE_MID;
  localparam int PMAX  = (PMAX0 > PAUSE_FAST) ? PMAX0 : PAUSE_FAST;
  localparam int PW    = $clog2(PMAX + 1);
  localparam int CW    = $clog2(2 * HALF_CLKS + PMAX + 1);
  localparam int BW    = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_LE, S_GAP} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bit_q;
  logic            blk;
  logic [WORD_W-1:0] sh, wb;
  logic [PW-1:0]   pause_q, sel_pause;
  logic            dev_on_q, start;

  assign sel_pause = (rate_sel == 2'b00) ? PW'(PAUSE_SLOW) :
                     (rate_sel == 2'b01) ? PW'(PAUSE_MID)  : PW'(PAUSE_FAST);
  assign start    = (st == S_IDLE) && fn_en && dev_on && !dev_on_q;

  assign syn_clk  = (st == S_HI);
  assign syn_le   = (st == S_LE);
  assign syn_data = (st == S_LO || st == S_HI) ? sh[WORD_W-1] : 1'b0;
  assign busy     = (st != S_IDLE);
  assign osc_en   = busy;

  function automatic logic [CW-1:0] low_len(input logic [BW-1:0] b, input logic [PW-1:0] p);
    return CW'(HALF_CLKS - 1) + ((b == BW'(PAUSE_BIT - 1)) ? CW'(p) : CW'(0));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bit_q <= '0; blk <= 1'b0;
      sh <= '0; wb <= '0; pause_q <= '0; dev_on_q <= 1'b0;
    end else begin
      dev_on_q <= dev_on;
      case (st)
        S_IDLE: if (start) begin
          sh <= word_a; wb <= word_b; pause_q <= sel_pause;
          blk <= 1'b0; bit_q <= '0; st <= S_LO;
          cnt <= low_len('0, sel_pause);
        end
        S_LO: if (cnt == 0) begin
          st <= S_HI; cnt <= CW'(HALF_CLKS - 1);
        end else cnt <= cnt - 1'b1;
        S_HI: if (cnt == 0) begin
          if (bit_q == BW'(WORD_W - 1)) begin
            st <= S_LE; cnt <= CW'(2 * HALF_CLKS - 1);
          end else begin
            st <= S_LO; bit_q <= bit_q + 1'b1; sh <= sh << 1;
            cnt <= low_len(bit_q + 1'b1, pause_q);
          end
        end else cnt <= cnt - 1'b1;
        S_LE: if (cnt == 0) begin
          if (!blk) begin
            st <= S_GAP; blk <= 1'b1;
            cnt <= CW'(HALF_CLKS - 1) + CW'(pause_q);
          end else st <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_GAP: if (cnt == 0) begin
          st <= S_LO; sh <= wb; bit_q <= '0;
          cnt <= low_len('0, pause_q);
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5: data held while the serial clock stays high
  a_r5_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    syn_clk && $past(syn_clk) |-> $stable(syn_data));

  // R2: a transfer begins only after an enabled OFF-to-ON edge
  a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fn_en) && $past(dev_on) && !$past(dev_on_q));

  // R8: latch pulse follows a clock-high phase
  a_r8_le_after_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syn_le) |-> $past(syn_clk));

  // R10: a transfer ends only out of the second latch pulse
  a_r10_end_from_le: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(syn_le) && blk);

  // R8: latch and clock never high together
  a_r8_le_clk_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(syn_le && syn_clk));
endmodule

// File: tb/synth_loader_test.sv
`timescale 1ns/1ps
module synth_loader_test;
  localparam int W = 24, H = 2, PB = 13;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] word_a = '0, word_b = '0;
  logic [1:0] rate_sel = 2'b00;
  logic fn_en = 0, dev_on = 0;
  logic syn_data, syn_clk, syn_le, osc_en, busy;
  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  synth_loader #(.WORD_W(W), .HALF_CLKS(H), .PAUSE_BIT(PB)) uut (
    .clk(clk), .rst_n(rst_n), .word_a(word_a), .word_b(word_b), .rate_sel(rate_sel),
    .fn_en(fn_en), .dev_on(dev_on), .syn_data(syn_data), .syn_clk(syn_clk),
    .syn_le(syn_le), .osc_en(osc_en), .busy(busy));

  function automatic int pause_of(input logic [1:0] s);
    return (s == 2'b00) ? 119 : (s == 2'b01) ? 33 : 1;
  endfunction

  logic [2:0] q[$];
  logic [2:0] cur = '0;
  logic mbusy = 0, mprev = 0;
  int exp_len = 0, run = 0;

  task automatic push_word(input logic [W-1:0] w, input int p);
    for (int i = 0; i < W; i++) begin
      for (int k = 0; k < H + ((i == PB - 1) ? p : 0); k++) q.push_back({w[W-1-i], 2'b00});
      for (int k = 0; k < H; k++) q.push_back({w[W-1-i], 2'b10});
    end
    for (int k = 0; k < 2 * H; k++) q.push_back(3'b001);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      cur = '0; mbusy = 0; mprev = 0; q.delete();
    end else begin
      if (q.size() > 0) begin cur = q.pop_front(); mbusy = 1; end
      else if (!mbusy && fn_en && dev_on && !mprev) begin
        int p;
        p = pause_of(rate_sel);
        push_word(word_a, p);
        for (int k = 0; k < H + p; k++) q.push_back(3'b000);
        push_word(word_b, p);
        exp_len = 2 * (W * 2 * H + p + 2 * H) + H + p;
        cur = q.pop_front(); mbusy = 1;
      end else begin cur = '0; mbusy = 0; end
      mprev = dev_on;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if ({syn_data, syn_clk, syn_le, busy, osc_en} != {cur, mbusy, mbusy}) begin
        fails++;
        if (syn_data != cur[2]) $display("FAIL R4 data t=%0d actual %0b expected %0b", cycles, syn_data, cur[2]);
        if (syn_clk != cur[1]) $display("FAIL R5 clk t=%0d actual %0b expected %0b", cycles, syn_clk, cur[1]);
        if (syn_le != cur[0]) $display("FAIL R8 le t=%0d actual %0b expected %0b", cycles, syn_le, cur[0]);
        if (busy != mbusy || osc_en != mbusy)
          $display("FAIL R10 busy/osc t=%0d actual %0b/%0b expected %0b", cycles, busy, osc_en, mbusy);
      end
      if (busy) run++;
      else if (run != 0) begin
        checks++;
        if (run != exp_len) begin
          fails++;
          $display("FAIL R6 R7 R9 transfer length actual %0d expected %0d", run, exp_len);
        end
        run = 0;
      end
    end
  end

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog actual %0d cycles expected completion", cycles);
      finish_up();
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic transfer(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] s);
    @(negedge clk);
    word_a = a; word_b = b; rate_sel = s; fn_en = 1; dev_on = 1;
    wait_n(3);
    while (busy) @(negedge clk);
    dev_on = 0;
    wait_n(3);
  endtask

  initial begin
    wait_n(3);
    checks++;
    if ({syn_data, syn_clk, syn_le, osc_en, busy} != 5'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %05b expected 00000", {syn_data, syn_clk, syn_le, osc_en, busy});
    end
    rst_n = 1;
    wait_n(2);
    // R3: rise with function disabled
    fn_en = 0; dev_on = 1; wait_n(20);
    checks++;
    if (busy) begin fails++; $display("FAIL R3 disabled start actual busy=1 expected 0"); end
    // R3: held high, then enabled without a new rise
    fn_en = 1; wait_n(20);
    checks++;
    if (busy) begin fails++; $display("FAIL R3 held-high start actual busy=1 expected 0"); end
    dev_on = 0; wait_n(3);
    // R2 R4 R6 R7 R9: each rate code
    transfer(24'hA5C3F0, 24'h0F1E2D, 2'b00);
    transfer(24'h800001, 24'hFFFFFF, 2'b01);
    transfer(24'h123456, 24'h000000, 2'b10);
    transfer(24'hFEDCBA, 24'h5A5A5A, 2'b11);
    // R10: retrigger and input change while busy
    @(negedge clk);
    word_a = 24'h3C3C3C; word_b = 24'hC3C3C3; rate_sel = 2'b01; fn_en = 1; dev_on = 1;
    wait_n(40);
    dev_on = 0; word_a = 24'hFFFFFF; word_b = 24'h000000; rate_sel = 2'b00;
    wait_n(2); dev_on = 1; wait_n(150); dev_on = 0; wait_n(2); dev_on = 1;
    while (busy) @(negedge clk);
    dev_on = 0; wait_n(5);
    checks++;
    if (busy) begin fails++; $display("FAIL R10 idle after retrigger actual busy=1 expected 0"); end
    finish_up();
  end
endmodule